// File: doc/BRIEF.md
# Packed Signed Multiply-High Unit

This block is a pipelined SIMD multiplier for a datapath that carries packed 16-bit lanes. Each operation brings two operand vectors and a width select. In every lane the two 16-bit values are multiplied as two's-complement numbers into a full 32-bit product. Only the upper half of that product is returned, in the same lane position it came from. No condition flags are produced or changed.

The unit accepts either a narrow operation (four lanes, 64 bits) or a wide operation (eight lanes, 128 bits). The hardware has four physical multipliers. A wide operation therefore passes through them as two back-to-back beats, and the two halves are joined again at the output. This gives one narrow operation per cycle, or one wide operation every two cycles.

Operations enter and leave through valid/ready handshakes. When the consumer holds ready low, the whole pipeline stalls. A synchronous active-high reset empties the pipeline.

Top module: `pmh_unit`

## Requirements
- R1: Each result lane equals bits 31:16 of the signed 32-bit product of the two operand lanes; the low 16 bits are dropped.
- R2: Lane i occupies bits 16i+15 down to 16i. Lane i of `in_a` pairs only with lane i of `in_b`, and the result goes to lane i of `out_data`.
- R3: With `in_wide`=0, four lanes over bits 63:0 are computed. `out_data[127:64]` is zero, and operand bits 127:64 have no effect on the result.
- R4: With `in_wide`=1, all eight lanes over bits 127:0 are computed.
- R5: 0x8000 times 0x8000 gives 0x4000 in that lane, with no saturation.
- R6: In the cycle after a wide operation is accepted, `in_ready` is low. Narrow operations can be accepted in consecutive cycles.
- R7: With no stall, a narrow operation accepted at a clock edge raises `out_valid` DEPTH-1 edges later. A wide operation does so DEPTH edges later.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next cycle `out_valid` stays high and `out_data` is unchanged.
- R9: After reset, `out_valid` is low and `in_ready` is high. Operations in flight at reset are discarded.
- R10: Results leave in acceptance order, each exactly once, under any pattern of back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted when high together with in_valid |
| in_wide | input | 1 | 1 = eight lanes (128 bits), 0 = four lanes (64 bits) |
| in_a | input | 128 | First operand vector, 16-bit lanes |
| in_b | input | 128 | Second operand vector, 16-bit lanes |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result when high |
| out_data | output | 128 | Packed high halves of the lane products |

## Verification
A lane wired to the wrong slice, or a product taken as unsigned, corrupts the affected lane of that very result. That shows on the first compare after the latency. A lost or mistagged beat of a wide operation leaves one half of `out_data` wrong or stale, or breaks result ordering. A wrong stall or valid state shows within one cycle as changed data during back-pressure, a missing gap after a wide accept, or a shifted latency count.

// File: rtl/pmh_pkg.sv
package pmh_pkg;
  localparam int LANE_W = 16;
  localparam int VEC_W  = 128;
endpackage

// File: rtl/pmh_lane.sv
module pmh_lane #(
  parameter int LANE_W = pmh_pkg::LANE_W,
  localparam int PROD_W = 2 * LANE_W
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] hi
);
  logic signed [PROD_W-1:0] prod;

  assign prod = $signed(a) * $signed(b);
  assign hi   = LANE_W'(prod >>> LANE_W);
endmodule

// File: rtl/pmh_issue.sv
module pmh_issue #(
  parameter int VEC_W = pmh_pkg::VEC_W,
  localparam int HALF_W = VEC_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [VEC_W-1:0]  in_a,
  input  logic [VEC_W-1:0]  in_b,
  output logic              in_ready,
  output logic              iss_v,
  output logic              iss_wide,
  output logic              iss_last,
  output logic [HALF_W-1:0] iss_a,
  output logic [HALF_W-1:0] iss_b
);
  logic              pend_q;
  logic [HALF_W-1:0] hold_a_q, hold_b_q;

  assign in_ready = adv && !pend_q;
  assign iss_v    = pend_q || in_valid;
  assign iss_wide = pend_q ? 1'b1 : in_wide;
  assign iss_last = pend_q ? 1'b1 : !in_wide;
  assign iss_a    = pend_q ? hold_a_q : in_a[HALF_W-1:0];
  assign iss_b    = pend_q ? hold_b_q : in_b[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (adv) begin
      if (pend_q) pend_q <= 1'b0;
      else if (in_valid && in_wide) pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && !pend_q && in_valid && in_wide) begin
      hold_a_q <= in_a[VEC_W-1:HALF_W];
      hold_b_q <= in_b[VEC_W-1:HALF_W];
    end
  end

  AST_WIDE_GAP: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_wide |=> !in_ready); // R6
endmodule

// File: rtl/pmh_pipe.sv
module pmh_pipe #(
  parameter int DEPTH  = 8,
  parameter int LANE_W = pmh_pkg::LANE_W,
  parameter int NLANE  = 4,
  localparam int W = LANE_W * NLANE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         iss_v,
  input  logic         iss_wide,
  input  logic         iss_last,
  input  logic [W-1:0] iss_a,
  input  logic [W-1:0] iss_b,
  output logic         tail_v,
  output logic         tail_wide,
  output logic         tail_last,
  output logic [W-1:0] tail_r
);
  logic [DEPTH-1:0] v_q, wide_q, last_q;
  logic [W-1:0]     opa_q, opb_q, hi_c;
  logic [W-1:0]     res_q [1:DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else if (adv) v_q <= {v_q[DEPTH-2:0], iss_v};
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      wide_q   <= {wide_q[DEPTH-2:0], iss_wide};
      last_q   <= {last_q[DEPTH-2:0], iss_last};
      opa_q    <= iss_a;
      opb_q    <= iss_b;
      res_q[1] <= hi_c;
      for (int k = 2; k < DEPTH; k++) res_q[k] <= res_q[k-1];
    end
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    pmh_lane #(.LANE_W(LANE_W)) u_lane (
      .a  (opa_q[i*LANE_W +: LANE_W]),
      .b  (opb_q[i*LANE_W +: LANE_W]),
      .hi (hi_c[i*LANE_W +: LANE_W])
    );

    AST_LANE_SIGN: assert property (@(posedge clk) disable iff (rst)
      adv && v_q[0] |=> res_q[1][i*LANE_W + LANE_W - 1] ==
        ($past(opa_q[i*LANE_W + LANE_W - 1] ^ opb_q[i*LANE_W + LANE_W - 1]) &&
         $past(opa_q[i*LANE_W +: LANE_W]) != '0 &&
         $past(opb_q[i*LANE_W +: LANE_W]) != '0)); // R1

    AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (rst)
      adv && v_q[0] &&
      opa_q[i*LANE_W +: LANE_W] == {1'b1, {(LANE_W-1){1'b0}}} &&
      opb_q[i*LANE_W +: LANE_W] == {1'b1, {(LANE_W-1){1'b0}}}
      |=> res_q[1][i*LANE_W +: LANE_W] == {2'b01, {(LANE_W-2){1'b0}}}); // R5
  end

  assign tail_v    = v_q[DEPTH-1];
  assign tail_wide = wide_q[DEPTH-1];
  assign tail_last = last_q[DEPTH-1];
  assign tail_r    = res_q[DEPTH-1];
endmodule

// File: rtl/pmh_unit.sv
module pmh_unit #(
  parameter int DEPTH  = 8,
  parameter int LANE_W = pmh_pkg::LANE_W,
  parameter int VEC_W  = pmh_pkg::VEC_W,
  localparam int HALF_W     = VEC_W / 2,
  localparam int HALF_LANES = HALF_W / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_wide,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  logic              adv, iss_v, iss_wide, iss_last;
  logic [HALF_W-1:0] iss_a, iss_b, tail_r, lo_save_q;
  logic              tail_v, tail_wide, tail_last;

  assign out_valid = tail_v && tail_last;
  assign adv       = !out_valid || out_ready;

  pmh_issue #(.VEC_W(VEC_W)) u_issue (
    .clk, .rst, .adv, .in_valid, .in_wide, .in_a, .in_b, .in_ready,
    .iss_v, .iss_wide, .iss_last, .iss_a, .iss_b
  );

  pmh_pipe #(.DEPTH(DEPTH), .LANE_W(LANE_W), .NLANE(HALF_LANES)) u_pipe (
    .clk, .rst, .adv, .iss_v, .iss_wide, .iss_last, .iss_a, .iss_b,
    .tail_v, .tail_wide, .tail_last, .tail_r
  );

  always_ff @(posedge clk) begin
    if (adv && tail_v && !tail_last) lo_save_q <= tail_r;
  end

  assign out_data = tail_wide ? {tail_r, lo_save_q} : {{HALF_W{1'b0}}, tail_r};

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && in_ready); // R9
endmodule

// File: tb/pmh_unit_bench.sv
module pmh_unit_bench;
  localparam int DEPTH = 8;
  localparam int VW    = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_wide = 1'b0, out_ready = 1'b0;
  logic [VW-1:0] in_a = '0, in_b = '0;
  logic          in_ready, out_valid;
  logic [VW-1:0] out_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [VW-1:0] exp_q[$];
  bit            wide_q[$];
  bit            prev_stall = 0, prev_wacc = 0;
  logic [VW-1:0] prev_data;

  always #2 clk = ~clk;

  pmh_unit #(.DEPTH(DEPTH)) u_pmh_unit (
    .clk, .rst, .in_valid, .in_ready, .in_wide, .in_a, .in_b,
    .out_valid, .out_ready, .out_data
  );

  function automatic logic [15:0] ref_hi(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] p;
    p = $signed(a) * $signed(b);
    return p[31:16];
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] a, input logic [VW-1:0] b, input bit wide);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < (wide ? 8 : 4); i++) r[i*16 +: 16] = ref_hi(a[i*16 +: 16], b[i*16 +: 16]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", '0, '0);
      finish_run();
    end
  end

  // one cycle: drive at negedge, observe, then cross the posedge
  task automatic step(input bit v, input bit w, input logic [VW-1:0] a, input logic [VW-1:0] b, input bit ordy);
    in_valid = v; in_wide = w; in_a = a; in_b = b; out_ready = ordy;
    #1;
    if (prev_stall) check(out_valid && out_data == prev_data, "R8 hold", out_data, prev_data);
    if (prev_stall) check(!in_ready || out_ready, "R8 in_ready", {127'd0, in_ready}, '0);
    if (prev_wacc) check(!in_ready, "R6 gap after wide", {127'd0, in_ready}, '0);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R10 extra result", out_data, '0);
      else begin
        logic [VW-1:0] e = exp_q.pop_front();
        bit wd = wide_q.pop_front();
        check(out_data == e, wd ? "R1 R2 R4 R10 wide" : "R1 R2 R3 R10 narrow", out_data, e);
      end
    end
    prev_wacc = in_valid && in_ready && in_wide;
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_vec(in_a, in_b, in_wide));
      wide_q.push_back(in_wide);
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic drain();
    for (int i = 0; i < 3 * DEPTH; i++) step(0, 0, '0, '0, 1);
    check(exp_q.size() == 0, "R10 all results delivered", VW'(exp_q.size()), '0);
    prev_stall = 0; prev_wacc = 0;
  endtask

  task automatic latency(input bit w);
    int cnt = 0;
    logic [VW-1:0] a = rnd_vec(), b = rnd_vec(), e;
    e = ref_vec(a, b, w);
    in_valid = 1; in_wide = w; in_a = a; in_b = b; out_ready = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    #1;
    while (!out_valid && cnt < 50) begin
      @(posedge clk); @(negedge clk); #1; cnt++;
    end
    check(cnt == (w ? DEPTH : DEPTH - 1), "R7 latency", VW'(cnt), VW'(w ? DEPTH : DEPTH - 1));
    check(out_data == e, "R7 latency data", out_data, e);
    @(posedge clk); @(negedge clk);
    prev_stall = 0; prev_wacc = 0;
  endtask

  logic [15:0] edges [5] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h0001};

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check(!out_valid && in_ready, "R9 reset state", {126'd0, out_valid, in_ready}, 128'd1);
    @(negedge clk);

    // R5 directed minimum-square in every lane, both widths
    step(1, 1, {8{16'h8000}}, {8{16'h8000}}, 1);
    step(1, 0, {8{16'h8000}}, {8{16'h8000}}, 1);
    drain();

    // edge value pairs across lanes
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        logic [VW-1:0] a = '0, b = '0;
        for (int l = 0; l < 8; l++) begin
          a[l*16 +: 16] = edges[(i + l) % 5];
          b[l*16 +: 16] = edges[(j + 2*l) % 5];
        end
        step(1, (i + j) % 2 == 1, a, b, 1);
      end
    drain();

    // R3 upper operand bits must not leak into narrow results
    step(1, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0002_0003_0004}, {64'h8000_8000_8000_8000, 64'h7FFF_8000_FFFF_0100}, 1);
    drain();

    latency(0);
    latency(1);

    // R6 back-to-back narrow ops accepted every cycle
    in_valid = 1; in_wide = 0; out_ready = 1;
    for (int i = 0; i < 4; i++) begin
      in_a = rnd_vec(); in_b = rnd_vec(); #1;
      check(in_ready, "R6 narrow every cycle", {127'd0, in_ready}, 128'd1);
      exp_q.push_back(ref_vec(in_a, in_b, 0)); wide_q.push_back(0);
      @(posedge clk); @(negedge clk);
    end
    in_valid = 0;
    drain();

    // random traffic with back-pressure
    for (int n = 0; n < 3000; n++)
      step(($urandom() % 4) != 0, $urandom() % 2, rnd_vec(), rnd_vec(), ($urandom() % 3) != 0);
    drain();

    // R9 reset with operations in flight
    for (int n = 0; n < 6; n++) step(1, $urandom() % 2, rnd_vec(), rnd_vec(), 0);
    rst = 1; in_valid = 0;
    @(posedge clk); @(negedge clk);
    rst = 0; exp_q.delete(); wide_q.delete(); prev_stall = 0; prev_wacc = 0;
    #1;
    check(!out_valid && in_ready, "R9 flush on reset", {126'd0, out_valid, in_ready}, 128'd1);
    for (int i = 0; i < 2 * DEPTH; i++) begin
      out_ready = 1; #1;
      check(!out_valid, "R9 no stale result", {127'd0, out_valid}, '0);
      @(posedge clk); @(negedge clk);
    end

    for (int n = 0; n < 1000; n++)
      step(1, $urandom() % 2, rnd_vec(), rnd_vec(), ($urandom() % 2) == 0);
    drain();
    finish_run();
  end
endmodule